// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers the interrupt sources of a serial flash controller's transmit and receive FIFOs into one status word, qualifies that word with a mask, and drives a single registered interrupt line. Two of the sources are events: receive overflow and transmit underflow. These bits latch and stay set until software clears them. The other four sources are FIFO level conditions. Each is compared against a programmable watermark or against the FIFO depth on every cycle.

Software reaches the block through a simple word-addressed register bus. The bus has a select, a write strobe, a 3-bit address, write data and combinational read data. Status bits are cleared by writing 1. The mask is never written directly. One write-only port turns mask bits on, another write-only port turns them off, and a read-only view returns the current mask. Software therefore never needs a read-modify-write sequence. The FIFOs and the serial engine are outside the block and appear only as level counts and event pulses.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask reads 0, `irq_o` is 0, the transmit watermark (address 4) reads 1 and the receive watermark (address 5) reads 32.
- R2: A one-cycle pulse on `rx_ovf_evt` sets status bit 0, and the bit stays set after the pulse ends until it is cleared.
- R3: A one-cycle pulse on `tx_unf_evt` sets status bit 6, and the bit stays set after the pulse ends until it is cleared.
- R4: Writing to the status register (address 0) clears every event bit written as 1 and leaves bits written as 0 unchanged. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R5: The level bits follow their conditions one cycle after the inputs change. Bit 2 is set while `tx_level` is below the transmit watermark. Bit 3 is set while `tx_level` equals FIFO_DEPTH. Bit 4 is set while `rx_level` is at or above the receive watermark. Bit 5 is set while `rx_level` equals FIFO_DEPTH. Writing 1 to a level bit has no lasting effect while its condition holds.
- R6: Writing to address 1 sets each defined mask bit written as 1 and leaves the other mask bits alone. Address 3 reads the current mask.
- R7: Writing to address 2 clears each mask bit written as 1 and leaves the other mask bits alone.
- R8: Addresses 1 and 2 read as zero.
- R9: Bits 1 and 7 to 31 read as zero in both status and mask, even after 1s are written to them.
- R10: `irq_o` is high exactly one cycle after any bit is set in both status and mask, and it falls one cycle after no such bit remains.
- R11: Addresses 4 and 5 are writable. New watermark values take effect on bits 2 and 4 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| tx_level | input | LVL_W | Entries held in the transmit FIFO |
| rx_level | input | LVL_W | Entries held in the receive FIFO |
| rx_ovf_evt | input | 1 | Receive overflow pulse |
| tx_unf_evt | input | 1 | Transmit underflow pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume one bus access per cycle, FIFO level counts that never exceed FIFO_DEPTH, and event pulses that are synchronous to `clk`. The stimulus drives every input shortly after a rising edge. It keeps each access to a single cycle and moves the levels only between 0 and the depth. The one deliberate overlap is an underflow pulse issued in the same cycle as a clear of bit 6, which exercises the priority of set over clear.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;
   localparam int unsigned NUM_SRC     = 7;
   localparam int unsigned BIT_RXOVF   = 0;
   localparam int unsigned BIT_TXLOW   = 2;
   localparam int unsigned BIT_TXFULL  = 3;
   localparam int unsigned BIT_RXAVL   = 4;
   localparam int unsigned BIT_RXFULL  = 5;
   localparam int unsigned BIT_TXUNF   = 6;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_STICKY = 2'd1,
      SRC_LEVEL  = 2'd2
   } src_kind_e;

   typedef enum logic [2:0] {
      REG_STATUS = 3'd0,
      REG_MSET   = 3'd1,
      REG_MCLR   = 3'd2,
      REG_MASK   = 3'd3,
      REG_TXWM   = 3'd4,
      REG_RXWM   = 3'd5
   } reg_sel_e;

   function automatic src_kind_e src_kind(input int unsigned b);
      if (b == BIT_RXOVF || b == BIT_TXUNF) return SRC_STICKY;
      if (b == BIT_TXLOW || b == BIT_TXFULL || b == BIT_RXAVL || b == BIT_RXFULL)
         return SRC_LEVEL;
      return SRC_NONE;
   endfunction
endpackage

// File: rtl/irq_level_detect.sv
`timescale 1ns/1ps
module irq_level_detect
   import irq_stat_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 63,
   parameter int unsigned LVL_W      = 6
) (
   input  logic [LVL_W-1:0]   tx_level,
   input  logic [LVL_W-1:0]   rx_level,
   input  logic [LVL_W-1:0]   tx_wm,
   input  logic [LVL_W-1:0]   rx_wm,
   output logic [NUM_SRC-1:0] lvl_cond
);
   localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(FIFO_DEPTH);

   always_comb begin
      lvl_cond             = '0;
      lvl_cond[BIT_TXLOW]  = (tx_level < tx_wm);
      lvl_cond[BIT_TXFULL] = (tx_level == FULL_CNT);
      lvl_cond[BIT_RXAVL]  = (rx_level >= rx_wm);
      lvl_cond[BIT_RXFULL] = (rx_level == FULL_CNT);
   end
endmodule

// File: rtl/irq_status_bits.sv
`timescale 1ns/1ps
module irq_status_bits
   import irq_stat_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_in,
   input  logic [NUM_SRC-1:0] lvl_in,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] status_o
);
   logic unused_srcs;
   assign unused_srcs = ^{evt_in, lvl_in, clr_bits};

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      if (src_kind(b) == SRC_STICKY) begin : g_sticky
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)          q <= 1'b0;
            else if (evt_in[b])  q <= 1'b1;
            else if (clr_bits[b]) q <= 1'b0;
         end
         assign status_o[b] = q;

         // R2
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !clr_bits[b]) |=> q);
         // R4
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_in[b] |=> status_o[b]);
      end else if (src_kind(b) == SRC_LEVEL) begin : g_level
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= lvl_in[b];
         end
         assign status_o[b] = q;

         // R5
         level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_in[b] && clr_bits[b]) |=> status_o[b]);
      end else begin : g_none
         assign status_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg
   import irq_stat_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic               clr_stb,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_o
);
   logic unused_wbits;
   assign unused_wbits = ^wbits;

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      if (src_kind(b) != SRC_NONE) begin : g_live
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 q <= 1'b0;
            else if (set_stb && wbits[b]) q <= 1'b1;
            else if (clr_stb && wbits[b]) q <= 1'b0;
         end
         assign mask_o[b] = q;

         // R6
         mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_stb && wbits[b]) |=> mask_o[b]);
         // R7
         mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && wbits[b]) |=> !mask_o[b]);
      end else begin : g_tied
         assign mask_o[b] = 1'b0;
      end
   end

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(mask_o));
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
   import irq_stat_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 63,
   parameter int unsigned TX_WM_INIT = 1,
   parameter int unsigned RX_WM_INIT = 32,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_ovf_evt,
   input  logic              tx_unf_evt,
   output logic              irq_o
);
   if (DATA_W < NUM_SRC) begin : g_bad_width
      $error("DATA_W must hold every status bit");
   end
   if (DATA_W < LVL_W) begin : g_bad_wm
      $error("DATA_W must hold a watermark value");
   end
   if (TX_WM_INIT > FIFO_DEPTH || RX_WM_INIT > FIFO_DEPTH) begin : g_bad_init
      $error("watermark reset value exceeds FIFO depth");
   end

   logic               wr_stb;
   logic [NUM_SRC-1:0] wbits;
   logic [LVL_W-1:0]   tx_wm_q, rx_wm_q;
   logic [NUM_SRC-1:0] lvl_cond, evt_vec, clr_vec;
   logic [NUM_SRC-1:0] status, mask;
   logic               irq_q;
   logic               unused_wdata;

   assign wr_stb       = bus_sel && bus_wr;
   assign wbits        = bus_wdata[NUM_SRC-1:0];
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_wm_q <= LVL_W'(TX_WM_INIT);
         rx_wm_q <= LVL_W'(RX_WM_INIT);
      end else if (wr_stb) begin
         if (bus_addr == REG_TXWM) tx_wm_q <= bus_wdata[LVL_W-1:0];
         if (bus_addr == REG_RXWM) rx_wm_q <= bus_wdata[LVL_W-1:0];
      end
   end

   irq_level_detect #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) i_level (
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_wm    (tx_wm_q),
      .rx_wm    (rx_wm_q),
      .lvl_cond (lvl_cond)
   );

   always_comb begin
      evt_vec            = '0;
      evt_vec[BIT_RXOVF] = rx_ovf_evt;
      evt_vec[BIT_TXUNF] = tx_unf_evt;
      clr_vec            = (wr_stb && bus_addr == REG_STATUS) ? wbits : '0;
   end

   irq_status_bits i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_vec),
      .lvl_in   (lvl_cond),
      .clr_bits (clr_vec),
      .status_o (status)
   );

   irq_mask_reg i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_stb && bus_addr == REG_MSET),
      .clr_stb (wr_stb && bus_addr == REG_MCLR),
      .wbits   (wbits),
      .mask_o  (mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status & mask);
   end
   assign irq_o = irq_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_STATUS: bus_rdata[NUM_SRC-1:0] = status;
         REG_MASK:   bus_rdata[NUM_SRC-1:0] = mask;
         REG_TXWM:   bus_rdata[LVL_W-1:0]   = tx_wm_q;
         REG_RXWM:   bus_rdata[LVL_W-1:0]   = rx_wm_q;
         default:    bus_rdata              = '0;
      endcase
   end

   // R10
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(mask != '0));
   // R10
   irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(status != '0));
   // R11
   wm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(tx_wm_q) && $stable(rx_wm_q)));
endmodule

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
   localparam int unsigned DEPTH = 63;
   localparam int unsigned LW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [LW-1:0] tx_level = '0, rx_level = '0;
   logic          rx_ovf_evt = 1'b0, tx_unf_evt = 1'b0;
   logic          irq_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_status_ctrl i_irq_status_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_level(tx_level), .rx_level(rx_level),
      .rx_ovf_evt(rx_ovf_evt), .tx_unf_evt(tx_unf_evt), .irq_o(irq_o)
   );

   // monitor: compares each read against the scoreboard queue
   always @(negedge clk) begin
      if (bus_sel && !bus_wr) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: unexpected read got %h expected none", bus_rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      step();
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      n_chk++;
      if (irq_o !== e) begin
         n_fail++;
         $display("FAIL %s: irq got %b expected %b", t, irq_o, e);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset values
      chk_irq(1'b0, "R1 irq after reset");
      rd(3'd3, 32'h0, "R1 mask after reset");
      rd(3'd4, 32'd1, "R1 tx watermark reset");
      rd(3'd5, 32'd32, "R1 rx watermark reset");
      // R5 empty tx fifo below watermark 1
      rd(3'd0, 32'h04, "R5 idle status");
      // R2 overflow sticky
      rx_ovf_evt = 1'b1; step(); rx_ovf_evt = 1'b0;
      rd(3'd0, 32'h05, "R2 overflow set");
      rd(3'd0, 32'h05, "R2 overflow held");
      // R4 clear by writing 1
      wr(3'd0, 32'h01);
      rd(3'd0, 32'h04, "R4 overflow cleared");
      // R5 clear of level bit has no lasting effect
      wr(3'd0, 32'h04);
      rd(3'd0, 32'h04, "R5 level bit reasserts");
      // R3 underflow sticky
      tx_unf_evt = 1'b1; step(); tx_unf_evt = 1'b0;
      rd(3'd0, 32'h44, "R3 underflow set");
      // R4 event and clear in same cycle: set wins
      tx_unf_evt = 1'b1;
      wr(3'd0, 32'h40);
      tx_unf_evt = 1'b0;
      rd(3'd0, 32'h44, "R4 set beats clear");
      wr(3'd0, 32'h40);
      rd(3'd0, 32'h04, "R4 underflow cleared");
      // R5 level conditions
      tx_level = LW'(DEPTH); step();
      rd(3'd0, 32'h08, "R5 tx full");
      rx_level = 6'd32; step();
      rd(3'd0, 32'h18, "R5 rx at watermark");
      rx_level = LW'(DEPTH); step();
      rd(3'd0, 32'h38, "R5 rx full");
      tx_level = '0; rx_level = '0; step();
      rd(3'd0, 32'h04, "R5 levels idle");
      // R11 watermarks
      wr(3'd4, 32'd5);
      rd(3'd4, 32'd5, "R11 tx watermark write");
      tx_level = 6'd3; step();
      rd(3'd0, 32'h04, "R11 tx below new watermark");
      tx_level = 6'd5; step();
      rd(3'd0, 32'h00, "R11 tx at new watermark");
      wr(3'd5, 32'd2);
      rd(3'd5, 32'd2, "R11 rx watermark write");
      rx_level = 6'd2; step();
      rd(3'd0, 32'h10, "R11 rx reaches new watermark");
      // R6 mask set, R9 undefined bits
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd3, 32'h7D, "R6 R9 mask set all");
      chk_irq(1'b1, "R10 irq from rx level");
      // R8 write-only ports
      rd(3'd1, 32'h0, "R8 set port reads zero");
      rd(3'd2, 32'h0, "R8 clear port reads zero");
      // R7 mask clear
      wr(3'd2, 32'h7C);
      rd(3'd3, 32'h01, "R7 mask partly cleared");
      chk_irq(1'b0, "R10 irq after mask clear");
      // R10 latency
      rx_ovf_evt = 1'b1; step(); rx_ovf_evt = 1'b0;
      chk_irq(1'b0, "R10 irq not before one cycle");
      step();
      chk_irq(1'b1, "R10 irq one cycle later");
      wr(3'd0, 32'h01);
      step();
      chk_irq(1'b0, "R10 irq falls after clear");
      // R9 reserved bits ignored
      wr(3'd0, 32'hFFFF_FF82);
      rd(3'd0, 32'h10, "R9 status reserved bits");
      wr(3'd1, 32'hFFFF_FF82);
      rd(3'd3, 32'h01, "R9 mask reserved bits");
      repeat (3) step();
      if (exp_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
      end
      report();
      $finish;
   end
endmodule